// File: doc/BRIEF.md
# Stretchable External Memory Cycle Generator

This block sits between a CPU's external-data-memory port and a shared memory that several masters reach. The CPU presents a read or write request with an address and, for a write, a data byte. The block runs one bus cycle: it drives the address, a read strobe or a write strobe, and, for a read, captures the memory's data. It then pulses a completion flag back to the CPU. The block's own stretch value lengthens every phase of the cycle, so a slow or contended memory can still be reached safely.

The stretch value is a small programmable field. Its reset value gives a cycle one clock longer than the fastest setting. Software may lower it to zero for speed or raise it for slower memory. The value is captured when a request is accepted, so a change made during a cycle only applies to later cycles. All widths are counted in CPU clocks. A read holds its address and its read strobe for stretch+1 clocks. A write holds its address for stretch+2 clocks. Its write strobe starts one clock after the address and lasts one clock at stretch 0, or stretch clocks otherwise.

Top module: `xmem_cycle_gen`

## Requirements
- R1: After reset the stretch field reads back as 1 on `cfg_stretch_q`.
- R2: A write through `cfg_we` loads `cfg_wdata` into the stretch field, visible on `cfg_stretch_q` one clock later, for every value from 0 to 7.
- R3: In a read cycle, `mem_addr_vld` and `mem_rd` are high together for exactly stretch+1 consecutive clocks, and `mem_addr` holds the request address throughout.
- R4: In a write cycle, `mem_addr_vld` is high for exactly stretch+2 consecutive clocks, with `mem_addr` holding the request address and `mem_wdata` holding the request data throughout.
- R5: In a write cycle, `mem_wr` rises on the second clock of the address window (window position 1, counting from 0). It stays high for 1 clock when stretch is 0, and for stretch clocks when stretch is 1 to 7.
- R6: For a read, `rd_data` takes the value of `mem_rdata` present on the last clock of the read strobe, and shows it while `done` is high.
- R7: `done` is a single-clock pulse, high on the clock right after the last clock of the address window.
- R8: `req_ready` is high only while no cycle is running. A request is taken only when `req_ready` and `req_valid` are both high. A `req_valid` raised during a cycle has no effect on that cycle's address or length.
- R9: A change to the stretch field made during a cycle does not alter that cycle's timing. The next cycle uses the new value.
- R10: `mem_rd` and `mem_wr` are never high at the same time, and neither is high outside the address window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the stretch field |
| cfg_wdata | input | SW (3) | New stretch value |
| cfg_stretch_q | output | SW (3) | Current stretch field |
| req_valid | input | 1 | CPU requests a memory cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | AW (12) | Cycle address |
| req_wdata | input | DW (8) | Write data |
| req_ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW (8) | Captured read data |
| mem_addr | output | AW (12) | Memory address |
| mem_addr_vld | output | 1 | Address window active |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW (8) | Memory write data |
| mem_rdata | input | DW (8) | Memory read data |

## Verification
The bench builds the block with its default parameters: a 3-bit stretch field, a 12-bit address and 8-bit data. At this size every stretch setting, from 0 to 7, can be swept for both reads and writes at several addresses. That sweep reaches both the special single-clock write strobe at stretch 0 and the longest nine-clock write window at stretch 7. The memory data changes on every clock, so reading it on any clock other than the last strobe clock gives a different value. Extra runs load the stretch field in the middle of a cycle and send requests while the block is busy.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic {
      XM_IDLE = 1'b0,
      XM_BUSY = 1'b1
   } xm_state_t;

   // last window index and strobe span are one wider than the stretch field
   function automatic int unsigned xm_cnt_width(input int unsigned sw);
      return sw + 1;
   endfunction
endpackage

// File: rtl/xmem_stretch_reg.sv
module xmem_stretch_reg #(
   parameter int unsigned SW          = 3,
   parameter int unsigned RST_STRETCH = 1,
   parameter bit          PROG        = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] wdata,
   output logic [SW-1:0] q
);
   localparam logic [SW-1:0] RST_VAL = SW'(RST_STRETCH);

   generate
      if (PROG) begin : g_prog
         logic [SW-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  val_q <= RST_VAL;
            else if (we) val_q <= wdata;
         end
         assign q = val_q;

         // R2
         load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> (q == $past(wdata)));
         // R2
         hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(q));
      end else begin : g_fixed
         assign q = RST_VAL;
      end
   endgenerate
endmodule

// File: rtl/xmem_width_dec.sv
module xmem_width_dec #(
   parameter int unsigned SW = 3,
   parameter int unsigned CW = SW + 1
) (
   input  logic [SW-1:0] stretch,
   output logic [CW-1:0] rd_last,
   output logic [CW-1:0] wr_last,
   output logic [CW-1:0] wr_span
);
   logic [CW-1:0] s_ext;
   assign s_ext = CW'(stretch);

   // window indices count from 0: read window stretch+1 long, write stretch+2
   always_comb begin
      rd_last = s_ext;
      wr_last = s_ext + CW'(1);
      if (stretch == '0) wr_span = CW'(1);
      else               wr_span = s_ext;
   end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
   import xmem_pkg::*;
#(
   parameter int unsigned SW = 3,
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 8,
   parameter int unsigned CW = SW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] stretch,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic [SW-1:0] lat_stretch,
   input  logic [CW-1:0] rd_last,
   input  logic [CW-1:0] wr_last,
   input  logic [CW-1:0] wr_span,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_addr_vld,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   xm_state_t     state_q;
   logic [CW-1:0] pos_q;
   logic          wr_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic [SW-1:0] s_q;
   logic          done_q;
   logic [DW-1:0] rdata_q;
   logic [CW-1:0] last_idx;
   logic          busy;
   logic          at_last;

   assign busy     = (state_q == XM_BUSY);
   assign last_idx = wr_q ? wr_last : rd_last;
   assign at_last  = busy && (pos_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XM_IDLE;
         pos_q   <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         s_q     <= '0;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            XM_IDLE: begin
               if (req_valid) begin
                  state_q <= XM_BUSY;
                  pos_q   <= '0;
                  wr_q    <= req_write;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  s_q     <= stretch;
               end
            end
            XM_BUSY: begin
               if (pos_q == last_idx) begin
                  state_q <= XM_IDLE;
                  done_q  <= 1'b1;
                  if (!wr_q) rdata_q <= mem_rdata;
               end else begin
                  pos_q <= pos_q + CW'(1);
               end
            end
            default: state_q <= XM_IDLE;
         endcase
      end
   end

   assign req_ready    = !busy;
   assign lat_stretch  = s_q;
   assign done         = done_q;
   assign rd_data      = rdata_q;
   assign mem_addr     = addr_q;
   assign mem_wdata    = wdata_q;
   assign mem_addr_vld = busy;
   assign mem_rd       = busy && !wr_q;
   assign mem_wr       = busy && wr_q && (pos_q != '0) && (pos_q <= wr_span);

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   // R10
   strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> mem_addr_vld);
   // R5
   wr_not_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_addr_vld) |-> !mem_wr);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   done_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_last |=> (done && !mem_addr_vld));
   // R3
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr_vld && !at_last) |=> ($stable(mem_addr) && mem_addr_vld));
   // R9
   stretch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr_vld && !at_last) |=> $stable(lat_stretch));
   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> (mem_addr_vld && (mem_addr == $past(req_addr))));
endmodule

// File: rtl/xmem_cycle_gen.sv
module xmem_cycle_gen #(
   parameter int unsigned SW          = 3,
   parameter int unsigned AW          = 12,
   parameter int unsigned DW          = 8,
   parameter int unsigned RST_STRETCH = 1,
   parameter bit          PROG        = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [SW-1:0] cfg_wdata,
   output logic [SW-1:0] cfg_stretch_q,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_addr_vld,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int unsigned CW = xmem_pkg::xm_cnt_width(SW);

   generate
      if (SW < 1 || SW > 6) begin : g_bad_sw
         $error("stretch field width out of range");
      end
      if (RST_STRETCH >= (1 << SW)) begin : g_bad_rst
         $error("reset stretch does not fit the field");
      end
      if (AW < 1 || DW < 1) begin : g_bad_bus
         $error("bus widths must be positive");
      end
   endgenerate

   logic [SW-1:0] s_live;
   logic [SW-1:0] s_cyc;
   logic [CW-1:0] rd_last;
   logic [CW-1:0] wr_last;
   logic [CW-1:0] wr_span;

   xmem_stretch_reg #(
      .SW(SW), .RST_STRETCH(RST_STRETCH), .PROG(PROG)
   ) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (s_live)
   );

   xmem_width_dec #(.SW(SW), .CW(CW)) u_dec (
      .stretch (s_cyc),
      .rd_last (rd_last),
      .wr_last (wr_last),
      .wr_span (wr_span)
   );

   xmem_seq #(.SW(SW), .AW(AW), .DW(DW), .CW(CW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .stretch      (s_live),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .req_ready    (req_ready),
      .lat_stretch  (s_cyc),
      .rd_last      (rd_last),
      .wr_last      (wr_last),
      .wr_span      (wr_span),
      .done         (done),
      .rd_data      (rd_data),
      .mem_addr     (mem_addr),
      .mem_addr_vld (mem_addr_vld),
      .mem_rd       (mem_rd),
      .mem_wr       (mem_wr),
      .mem_wdata    (mem_wdata),
      .mem_rdata    (mem_rdata)
   );

   assign cfg_stretch_q = s_live;
endmodule

// File: tb/test_xmem_cycle_gen.sv
module test_xmem_cycle_gen;
   localparam int SW = 3;
   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [SW-1:0] cfg_wdata = '0;
   logic [SW-1:0] cfg_stretch_q;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic          done;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_addr_vld;
   logic          mem_rd;
   logic          mem_wr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int done_seen = 0;

   // expectations for the running memory cycle
   int            e_s = 0;
   logic          e_wr = 1'b0;
   logic [AW-1:0] e_addr = '0;
   logic [DW-1:0] e_data = '0;

   // monitor state
   int            pos = 0;
   int            rd_cnt = 0;
   int            wr_cnt = 0;
   int            wr_first = -1;
   int            bad_addr = 0;
   int            bad_wr_pos = 0;
   int            bad_excl = 0;
   logic          prev_av = 1'b0;
   logic          prev_done = 1'b0;
   logic [DW-1:0] rec_rd = '0;
   logic [7:0]    lfsr = 8'h5a;

   always #5 clk = ~clk;

   xmem_cycle_gen i_xmem_cycle_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_stretch_q(cfg_stretch_q), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_addr_vld(mem_addr_vld), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // sample outputs, then advance the memory data, all at the falling edge
   always @(negedge clk) begin
      logic [7:0] nv;
      cyc++;
      if (cyc > 100000) begin
         chk(1'b0, "watchdog", cyc, 100000);
         finish_run();
      end
      nv = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (rst_n) begin
         if (mem_rd && mem_wr) bad_excl++;
         if ((mem_rd || mem_wr) && !mem_addr_vld) bad_excl++;
         if (mem_addr_vld) begin
            if (mem_addr != e_addr) bad_addr++;
            if (e_wr && mem_wdata != e_data) bad_addr++;
            if (mem_rd) begin
               rd_cnt++;
               rec_rd = nv;
            end
            if (mem_wr) begin
               wr_cnt++;
               if (wr_first < 0) wr_first = pos;
               if (pos < 1 || pos > ((e_s == 0) ? 1 : e_s)) bad_wr_pos++;
            end
            pos++;
         end
         if (prev_done && done) chk(1'b0, "R7 done wider than one clock", 2, 1);
         if (done) begin
            // R7: done right after the window closes
            chk(prev_av && !mem_addr_vld, "R7 done timing", int'(prev_av), 1);
            if (e_wr) begin
               chk(pos == e_s + 2, "R4 write address window", pos, e_s + 2);
               chk(wr_cnt == ((e_s == 0) ? 1 : e_s), "R5 write strobe width",
                   wr_cnt, (e_s == 0) ? 1 : e_s);
               chk(wr_first == 1 && bad_wr_pos == 0, "R5 write strobe position",
                   wr_first, 1);
               chk(rd_cnt == 0, "R10 no read strobe in write", rd_cnt, 0);
            end else begin
               chk(pos == e_s + 1, "R3 read address window", pos, e_s + 1);
               chk(rd_cnt == e_s + 1, "R3 read strobe width", rd_cnt, e_s + 1);
               chk(wr_cnt == 0, "R10 no write strobe in read", wr_cnt, 0);
               chk(rd_data == rec_rd, "R6 read data capture", rd_data, rec_rd);
            end
            chk(bad_addr == 0, "R3 R4 address and data held", bad_addr, 0);
            chk(bad_excl == 0, "R10 strobe exclusion", bad_excl, 0);
            pos = 0; rd_cnt = 0; wr_cnt = 0; wr_first = -1;
            bad_addr = 0; bad_wr_pos = 0; bad_excl = 0;
            done_seen++;
         end
      end
      prev_av   = mem_addr_vld;
      prev_done = done;
      lfsr      = nv;
      mem_rdata = nv;
   end

   task automatic set_stretch(input int s);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = SW'(s);
      @(negedge clk);
      cfg_we = 1'b0;
      chk(cfg_stretch_q == SW'(s), "R2 stretch load", cfg_stretch_q, s);
   endtask

   // optional: poke the stretch field or a stray request mid-cycle
   task automatic run_cycle(input bit wr, input int a, input int d, input int s,
                            input bit poke_cfg, input bit poke_req);
      int start;
      start = done_seen;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
      e_s = s; e_wr = wr; e_addr = AW'(a); e_data = DW'(d);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 ready low when busy", req_ready, 0);
      if (poke_cfg) begin
         cfg_we = 1'b1; cfg_wdata = SW'(7 - s);
      end
      if (poke_req) begin
         req_valid = 1'b1; req_write = !wr; req_addr = ~AW'(a);
      end
      @(negedge clk);
      cfg_we = 1'b0;
      req_valid = 1'b0;
      while (done_seen == start) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_addr_vld == 1'b0 && done == 1'b0, "reset outputs idle",
          int'(mem_addr_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(cfg_stretch_q == 3'd1, "R1 reset stretch", cfg_stretch_q, 1);
      chk(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
      run_cycle(1'b0, 12'h123, 0, 1, 1'b0, 1'b0);
      run_cycle(1'b1, 12'h456, 8'h9c, 1, 1'b0, 1'b0);
      for (int s = 0; s < 8; s++) begin
         set_stretch(s);
         for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 3; k++) begin
               run_cycle(w[0], (s * 301 + k * 1237 + w * 77) & 12'hfff,
                         (s * 37 + k * 91 + 5) & 8'hff, s, 1'b0, 1'b0);
            end
         end
      end
      // R9: stretch changed during a cycle; current cycle keeps old timing
      set_stretch(2);
      run_cycle(1'b1, 12'h0a5, 8'h3c, 2, 1'b1, 1'b0);
      chk(cfg_stretch_q == 3'd5, "R9 new stretch stored", cfg_stretch_q, 5);
      run_cycle(1'b0, 12'h0b6, 0, 5, 1'b0, 1'b0);
      set_stretch(0);
      run_cycle(1'b0, 12'h7e1, 0, 0, 1'b1, 1'b0);
      run_cycle(1'b1, 12'h7e2, 8'h11, 7, 1'b0, 1'b0);
      // R8: stray requests while busy have no effect
      set_stretch(4);
      run_cycle(1'b0, 12'h321, 0, 4, 1'b0, 1'b1);
      run_cycle(1'b1, 12'hfed, 8'hc3, 4, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      chk(mem_addr_vld == 1'b0, "R8 no cycle from ignored request",
          int'(mem_addr_vld), 0);
      finish_run();
   end
endmodule